// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from up to 32 sources and passes one of them at a time to a small processor core. Each source has a sticky pending flag and an enable bit of its own. A global enable input from the core gates all maskable sources at once. A programmable priority threshold holds back the low-priority sources. The topmost source cannot be masked.

The block registers the chosen request as an `irq_o` line. With it comes the fixed vector-slot address of the winning source, in a table at the top of a 16-bit address space. The core acknowledges with `irq_ack_i`. At that point the flag of a source that owns its vector alone is cleared by the hardware. Sources marked as shared keep their flag until software clears it through the flag register. A three-register write/read port gives access to the enables, the flags and the threshold.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Any cycle in which `src_req_i[i]` is 1 sets pending flag i at the next clock edge. The flag stays set until it is cleared, and it reads back as bit i at register address 1.
- R2: A maskable source i (below index 31) is eligible only when `gie_i` is 1, enable bit i is 1 and flag i is 1. Enable bits are written and read at register address 0, bit i for source i.
- R3: A flag set while its source is not eligible stays pending. It raises `irq_o` once the enables allow it.
- R4: Source 31 is non-maskable. It is eligible whenever its flag is set, whatever the values of `gie_i`, its enable bit and the threshold.
- R5: When several sources are eligible, the one with the highest index is selected.
- R6: A maskable source i is eligible only when i+1 is greater than the threshold. The threshold is a 6-bit value at register address 2 and resets to 0.
- R7: The vector output equals 0xFFC0 + 2*i for selected source i.
- R8: `irq_o` rises on the clock edge after a source becomes eligible while `irq_o` is low. It then holds, together with the vector, until a cycle with `irq_ack_i` high. It falls at the next edge and stays low for at least one cycle.
- R9: On acknowledge, the flag of the selected source is cleared, unless that source is marked shared (sources 4 and 5 by default). A shared flag stays set.
- R10: Writing 1s to register address 1 clears those flags. If a request and a clear (by write or by acknowledge) hit the same flag in the same cycle, the request wins. Register address 3 reads 0.
- R11: After reset, `irq_o` is 0, the vector is 0xFFC0, and the flags, enables and threshold read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 32 | Request inputs, one per source |
| gie_i | input | 1 | Global enable for maskable sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_ack_i | input | 1 | Acknowledge from the core |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Vector-slot address of the selected source |

## Verification
Two things can land on the same flag in one cycle: a clear, from the acknowledge or from the write-1-to-clear register, and a fresh request for that same source. The bench provokes both cases on purpose. It raises the source's request in the very cycle the core acknowledges it. Separately, it writes the clear mask while the request pulses. In each case it then reads the flag register and expects the bit to remain set. A behavioural reference model, stepped on every clock, also judges these collisions during a long run with random requests, acknowledges and register writes.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_FLAGS  = 2'd1,
    REG_THRESH = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] SHARED_MASK = '0,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] w1c_i,
  input  logic             ack_fire_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_SRC-1:0] flag_o
);
  logic [N_SRC-1:0] flag_q, flag_d, ack_clr;
  logic             flag_en;

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    if (SHARED_MASK[i]) begin : g_shared
      assign ack_clr[i] = 1'b0;
    end else begin : g_single
      assign ack_clr[i] = ack_fire_i && (ack_idx_i == IDX_W'(i));
    end
  end

  always_comb begin
    flag_en = |(src_req_i | ack_clr | w1c_i);
    flag_d  = (flag_q & ~(ack_clr | w1c_i)) | src_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_req_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req_i) |=> ((flag_q & $past(src_req_i)) == $past(src_req_i)));

  assert_single_autoclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire_i && !SHARED_MASK[ack_idx_i] && !src_req_i[ack_idx_i])
      |=> !flag_q[$past(ack_idx_i)]);

  assert_shared_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire_i && SHARED_MASK[ack_idx_i] && flag_q[ack_idx_i] && !w1c_i[ack_idx_i])
      |=> flag_q[$past(ack_idx_i)]);
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int BUS_W = 32,
  localparam int THR_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [N_SRC-1:0] flag_i,
  output logic [N_SRC-1:0] en_o,
  output logic [THR_W-1:0] thr_o,
  output logic [N_SRC-1:0] w1c_o,
  output logic [BUS_W-1:0] rdata_o
);
  reg_sel_e         sel;
  logic [N_SRC-1:0] en_q;
  logic [THR_W-1:0] thr_q;
  logic             en_load, thr_load;

  always_comb begin
    sel      = reg_sel_e'(addr_i);
    en_load  = we_i && (sel == REG_ENABLE);
    thr_load = we_i && (sel == REG_THRESH);
    w1c_o    = (we_i && (sel == REG_FLAGS)) ? wdata_i[N_SRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_load) en_q <= wdata_i[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= '0;
    else if (thr_load) thr_q <= wdata_i[THR_W-1:0];
  end

  always_comb begin
    unique case (sel)
      REG_ENABLE: rdata_o = BUS_W'(en_q);
      REG_FLAGS:  rdata_o = BUS_W'(flag_i);
      REG_THRESH: rdata_o = BUS_W'(thr_q);
      default:    rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign thr_o = thr_q;

  assert_thr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> (thr_o == $past(wdata_i[THR_W-1:0])));
endmodule

// File: rtl/ivc_select.sv
module ivc_select #(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int THR_W = $clog2(N_SRC + 1),
  localparam int NMI_IDX = N_SRC - 1
) (
  input  logic             gie_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [N_SRC-1:0] flag_i,
  output logic [N_SRC-1:0] elig_o,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    if (i == NMI_IDX) begin : g_nmi
      assign elig_o[i] = flag_i[i];
    end else begin : g_mask
      assign elig_o[i] = flag_i[i] && gie_i && en_i[i] && (32'(i + 1) > 32'(thr_i));
    end
  end

  always_comb begin
    win_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_o[i]) win_o = IDX_W'(i);
    end
    any_o = |elig_o;
  end
endmodule

// File: rtl/ivc_handshake.sv
module ivc_handshake #(
  parameter int N_SRC = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  win_i,
  input  logic [N_SRC-1:0]  elig_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              ack_fire_o
);
  logic              irq_q, irq_d, sel_load;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] vec_q, vec_d;

  always_comb begin
    ack_fire_o = irq_q && ack_i;
    sel_load   = !irq_q && any_i;
    irq_d      = irq_q ? !ack_i : any_i;
    vec_d      = VEC_BASE + ADDR_W'({win_i, 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      vec_q <= VEC_BASE;
    end else if (sel_load) begin
      idx_q <= win_i;
      vec_q <= vec_d;
    end
  end

  assign irq_o = irq_q;
  assign idx_o = idx_q;
  assign vec_o = vec_q;

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o) && $stable(idx_o)));

  assert_drop_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o);

  assert_highest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((($past(elig_i) >> idx_o) >> 1) == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 32,
  parameter int BUS_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0,
  parameter logic [N_SRC-1:0] SHARED_MASK = 32'h0000_0030,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int THR_W = $clog2(N_SRC + 1),
  localparam int NMI_IDX = N_SRC - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req_i,
  input  logic              gie_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] irq_vec_o
);
  logic             rst_meta_n, rst_sync_n;
  logic [N_SRC-1:0] flag_q, en_q, w1c, elig;
  logic [THR_W-1:0] thr_q;
  logic             any_elig, ack_fire;
  logic [IDX_W-1:0] win_idx, sel_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ivc_regs #(.N_SRC(N_SRC), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .flag_i(flag_q), .en_o(en_q), .thr_o(thr_q),
    .w1c_o(w1c), .rdata_o(reg_rdata_o)
  );

  ivc_flag_bank #(.N_SRC(N_SRC), .SHARED_MASK(SHARED_MASK)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .src_req_i(src_req_i), .w1c_i(w1c),
    .ack_fire_i(ack_fire), .ack_idx_i(sel_idx), .flag_o(flag_q)
  );

  ivc_select #(.N_SRC(N_SRC)) u_sel (
    .gie_i(gie_i), .en_i(en_q), .thr_i(thr_q), .flag_i(flag_q),
    .elig_o(elig), .any_o(any_elig), .win_o(win_idx)
  );

  ivc_handshake #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_hs (
    .clk(clk), .rst_n(rst_sync_n), .any_i(any_elig), .win_i(win_idx),
    .elig_i(elig), .ack_i(irq_ack_i), .irq_o(irq_o), .idx_o(sel_idx),
    .vec_o(irq_vec_o), .ack_fire_o(ack_fire)
  );

  assert_maskable_gated_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(irq_o) && (sel_idx != IDX_W'(NMI_IDX)))
      |-> ($past(gie_i) && (($past(en_q) & (N_SRC'(1) << sel_idx)) != '0)));

  assert_threshold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(irq_o) && (sel_idx != IDX_W'(NMI_IDX)))
      |-> ((32'(sel_idx) + 1) > 32'($past(thr_q))));

  assert_nmi_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_q[NMI_IDX] && !irq_o) |=> irq_o);

  assert_rise_from_pending_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> (($past(flag_q) & (N_SRC'(1) << sel_idx)) != '0));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  localparam logic [31:0] SHM = 32'h0000_0030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        gie = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_ack = 1'b0;
  logic        irq;
  logic [15:0] vec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  bit [31:0] m_flag = '0;
  bit [31:0] m_en = '0;
  int        m_thr = 0;
  bit        m_irq = 0;
  int        m_idx = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.SHARED_MASK(SHM)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .gie_i(gie),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_ack_i(irq_ack), .irq_o(irq), .irq_vec_o(vec)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, stepped on each clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = '0; m_en = '0; m_thr = 0; m_irq = 0; m_idx = 0;
    end else begin
      bit [31:0] nf;
      bit any;
      bit fire;
      int wi;
      any = 0; wi = 0;
      for (int i = 0; i < 32; i++)
        if (m_flag[i] && (i == 31 || (gie && m_en[i] && (i + 1) > m_thr))) begin
          any = 1; wi = i;
        end
      fire = m_irq && irq_ack;
      nf = m_flag;
      if (fire && !SHM[m_idx]) nf[m_idx] = 1'b0;
      if (reg_we && reg_addr == 2'd1) nf = nf & ~reg_wdata;
      nf = nf | src_req;
      if (m_irq) begin
        if (fire) m_irq = 0;
      end else if (any) begin
        m_irq = 1; m_idx = wi;
      end
      if (reg_we && reg_addr == 2'd0) m_en = reg_wdata;
      if (reg_we && reg_addr == 2'd2) m_thr = int'(reg_wdata[5:0]);
      m_flag = nf;
    end
  end

  // Per-cycle comparison against the model (R7, R8, R10)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [31:0] er;
      case (reg_addr)
        2'd0: er = m_en;
        2'd1: er = m_flag;
        2'd2: er = 32'(m_thr);
        default: er = '0;
      endcase
      chk("R8 model irq", 32'(irq), 32'(m_irq));
      chk("R7 model vector", 32'(vec), 32'(16'hFFC0 + 16'(2 * m_idx)));
      chk("R10 model rdata", reg_rdata, er);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse(logic [31:0] m);
    src_req = m;
    tick();
    src_req = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int n = 0; n < 10 && !irq; n++) tick();
  endtask

  task automatic ack1();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 40; n++) begin
      if (irq) ack1();
      else tick();
    end
  endtask

  initial begin
    logic [31:0] r;
    logic [15:0] v0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R11 reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R11 vector", 32'(vec), 32'h0000_FFC0);
    rd(2'd0, r); chk("R11 enable", r, 0);
    rd(2'd1, r); chk("R11 flags", r, 0);
    rd(2'd2, r); chk("R11 thresh", r, 0);
    rd(2'd3, r); chk("R10 spare reads 0", r, 0);

    // R1 latch while disabled, R2 gating
    pulse(32'h8);
    rd(2'd1, r); chk("R1 flag latched", r, 32'h8);
    tick(3);
    chk("R2 no irq with gie=0 en=0", 32'(irq), 0);
    gie = 1'b1;
    tick(2);
    chk("R2 no irq with en=0", 32'(irq), 0);
    wr(2'd0, 32'h8);
    wait_irq();
    chk("R3 pending serviced", 32'(irq), 1);
    chk("R7 vector src3", 32'(vec), 32'h0000_FFC6);
    v0 = vec;
    tick(3);
    chk("R8 held irq", 32'(irq), 1);
    chk("R8 held vector", 32'(vec), 32'(v0));
    ack1();
    chk("R8 drop after ack", 32'(irq), 0);
    rd(2'd1, r); chk("R9 single auto-clear", r, 0);

    // R9 shared, R10 write-1-to-clear
    wr(2'd0, 32'h0000_FFFF);
    pulse(32'h10);
    wait_irq();
    chk("R7 vector src4", 32'(vec), 32'h0000_FFC8);
    ack1();
    rd(2'd1, r); chk("R9 shared kept", r, 32'h10);
    wr(2'd1, 32'h10);
    rd(2'd1, r); chk("R10 w1c cleared", r, 0);
    drain();

    // R5 priority
    pulse(32'h284);
    wait_irq();
    chk("R5 first src9", 32'(vec), 32'h0000_FFD2);
    ack1(); wait_irq();
    chk("R5 second src7", 32'(vec), 32'h0000_FFCE);
    ack1(); wait_irq();
    chk("R5 third src2", 32'(vec), 32'h0000_FFC4);
    ack1();

    // R6 threshold
    wr(2'd2, 32'd8);
    rd(2'd2, r); chk("R10 thresh readback", r, 32'd8);
    pulse(32'h280);
    wait_irq();
    chk("R6 src9 above thresh", 32'(vec), 32'h0000_FFD2);
    ack1();
    tick(4);
    chk("R6 src7 held at thresh", 32'(irq), 0);
    rd(2'd1, r); chk("R6 src7 pending", r, 32'h80);
    wr(2'd2, 32'd7);
    wait_irq();
    chk("R6 src7 after lowering", 32'(vec), 32'h0000_FFCE);
    ack1();

    // R4 non-maskable source
    gie = 1'b0;
    wr(2'd2, 32'd32);
    wr(2'd0, 32'h0);
    pulse(32'h8000_0000);
    wait_irq();
    chk("R4 nmi irq", 32'(irq), 1);
    chk("R4 nmi vector", 32'(vec), 32'h0000_FFFE);
    ack1();
    rd(2'd1, r); chk("R4 nmi flag cleared", r, 0);

    // R9/R10 collision: ack and request on same source
    gie = 1'b1;
    wr(2'd2, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    pulse(32'h8);
    wait_irq();
    irq_ack = 1'b1; src_req = 32'h8;
    tick();
    irq_ack = 1'b0; src_req = '0;
    rd(2'd1, r); chk("R10 request beats ack clear", r, 32'h8);
    wait_irq();
    chk("R9 re-serviced src3", 32'(vec), 32'h0000_FFC6);
    ack1();
    rd(2'd1, r); chk("R9 cleared after second ack", r, 0);

    // R10 collision: w1c and request same cycle, source 5 disabled
    wr(2'd0, 32'hFFFF_FFDF);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h20; src_req = 32'h20;
    tick();
    reg_we = 1'b0; src_req = '0;
    rd(2'd1, r); chk("R10 request beats w1c", r, 32'h20);
    wr(2'd1, 32'h20);
    rd(2'd1, r); chk("R10 w1c src5", r, 0);
    drain();

    // Random phase, judged by the model each cycle
    for (int k = 0; k < 3000; k++) begin
      src_req  = $urandom & $urandom & $urandom & $urandom;
      gie      = ($urandom % 8) != 0;
      irq_ack  = irq && (($urandom % 3) == 0);
      reg_addr = 2'($urandom);
      reg_we   = ($urandom % 6) == 0;
      reg_wdata = (reg_addr == 2'd2) ? 32'($urandom % 34) : $urandom;
      tick();
    end
    reg_we = 1'b0; src_req = '0; irq_ack = 1'b0;
    tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule